// File: doc/BRIEF.md
# Page mapper with usage tracking

This block maps a processor address onto physical memory. The low 4 MB of the address space is split into 1024 pages of 4 KB. Each page has one 16-bit entry in an internal map table. An entry holds a physical page number, a two-bit usage state and a write-enable flag. For an address in that range, the block swaps the virtual page number for the entry's physical page number and keeps the page offset. Addresses above the range pass through unchanged.

Every accepted translation also updates the entry in place. An untouched page becomes "read" or "written", and a read page becomes "written" when it is stored to. A separate fault checker sees the stored usage state and write-enable bit. It returns a fault flag in the same cycle, and a faulting access leaves the entry as it was. The processor can also read and write the table as an 11-bit byte-addressed region. A processor write takes effect at the clock edge, and a read returns data in the same cycle.

Top module: `pgmap_xlate`

## Requirements
- R1: For an address whose bits 23..22 are both zero, xl_mapped is 1. The page index is address bits 21..12, and xl_paddr is {2'b00, entry[9:0], address[11:0]}, all in the same cycle.
- R2: For an address with bit 23 or bit 22 set, xl_mapped is 0 and xl_paddr equals the address. No table entry changes.
- R3: Entry bits 14..13 hold the usage state: 0 absent, 1 present and untouched, 2 present and read, 3 present and written. A valid, fault-free read of a state-1 page sets the state to 2 at the clock edge. Bit 15 and all other bits of the entry are kept.
- R4: A valid, fault-free write to a page in state 1, 2 or 3 leaves it in state 3. A read of a page in state 2 or 3 leaves the entry unchanged.
- R5: An entry in state 0 is never changed by a translation, and nothing changes while xl_valid is 0.
- R6: While xl_fault is 1, the accessed entry is not updated.
- R7: If a processor write lands in the same entry as a translation in the same cycle, the processor data is stored and the usage update is dropped, even for a byte write. If the two target different entries, both take effect.
- R8: On the processor port, the entry index is mp_addr bits 10..1. With mp_word=1, the whole entry is read or written and bit 0 is ignored. With mp_word=0, bit 0 = 0 selects entry bits 15..8 and bit 0 = 1 selects bits 7..0. Byte data travels in bits 7..0, and the upper byte of read data is zero.
- R9: xl_state and xl_wen show the stored bits 14..13 and bit 15 of the addressed entry as they stand before this access's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (the table itself is not cleared) |
| xl_valid | input | 1 | A translation is presented this cycle |
| xl_write | input | 1 | The access is a store |
| xl_addr | input | 24 | Processor address to translate |
| xl_fault | input | 1 | Fault verdict from the external checker for this access |
| xl_mapped | output | 1 | Address lies in the mapped range |
| xl_paddr | output | 24 | Physical address, or the input address when unmapped |
| xl_state | output | 2 | Usage state of the addressed entry before update |
| xl_wen | output | 1 | Write-enable bit of the addressed entry |
| mp_sel | input | 1 | Processor access to the map table |
| mp_we | input | 1 | Processor access is a write |
| mp_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| mp_addr | input | 11 | Byte address within the table |
| mp_wdata | input | 16 | Processor write data |
| mp_rdata | output | 16 | Processor read data |

## Verification
The read-modify-write of the usage state and a processor store into the table can fall in the same clock cycle. The bench provokes this by driving a translation and a processor write together. It does this for the same entry, both word-wide and with a single byte, and for two different entries. After the edge it reads the entries back through the processor port and compares them with a model. In that model the processor data wins on a shared entry, and both changes apply otherwise.

// File: rtl/pgmap_xlate.sv
module pgmap_xlate #(
  parameter int ADDR_W = 24,
  parameter int VPN_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  input  logic              xl_write,
  input  logic [ADDR_W-1:0] xl_addr,
  input  logic              xl_fault,
  output logic              xl_mapped,
  output logic [ADDR_W-1:0] xl_paddr,
  output logic [1:0]        xl_state,
  output logic              xl_wen,
  input  logic              mp_sel,
  input  logic              mp_we,
  input  logic              mp_word,
  input  logic [VPN_W:0]    mp_addr,
  input  logic [15:0]       mp_wdata,
  output logic [15:0]       mp_rdata
);
  localparam int ENTRIES = 1 << VPN_W;
  localparam int MAP_TOP = VPN_W + OFF_W;
  localparam int PA_W    = PPN_W + OFF_W;

  logic [15:0] mem [ENTRIES];

  logic [VPN_W-1:0] vpn, mp_idx;
  logic [15:0]      ent, mp_ent;
  logic [1:0]       nxt;
  logic             mp_wr, collide, upd;

  assign vpn       = xl_addr[OFF_W +: VPN_W];
  assign ent       = mem[vpn];
  assign xl_mapped = ~|xl_addr[ADDR_W-1:MAP_TOP];
  assign xl_state  = ent[14:13];
  assign xl_wen    = ent[15];
  assign xl_paddr  = xl_mapped ? {{(ADDR_W-PA_W){1'b0}}, ent[PPN_W-1:0], xl_addr[OFF_W-1:0]}
                               : xl_addr;

  assign mp_idx  = mp_addr[VPN_W:1];
  assign mp_ent  = mem[mp_idx];
  assign mp_wr   = mp_sel & mp_we;
  assign collide = mp_wr & (mp_idx == vpn);

  assign nxt = xl_write ? 2'd3 : ((xl_state == 2'd1) ? 2'd2 : xl_state);
  assign upd = xl_valid & xl_mapped & ~xl_fault & (|xl_state) & ~collide;

  assign mp_rdata = mp_word    ? mp_ent :
                    mp_addr[0] ? {8'h00, mp_ent[7:0]} : {8'h00, mp_ent[15:8]};

  always_ff @(posedge clk) begin
    if (mp_wr) begin
      if (mp_word)         mem[mp_idx]       <= mp_wdata;
      else if (mp_addr[0]) mem[mp_idx][7:0]  <= mp_wdata[7:0];
      else                 mem[mp_idx][15:8] <= mp_wdata[7:0];
    end
    if (upd) mem[vpn][14:13] <= nxt;
  end

  // R2
  unmapped_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !xl_mapped && !mp_wr) |=> mem[$past(vpn)] == $past(mem[vpn]));

  // R3
  first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_mapped && !xl_fault && !mp_wr && !xl_write && xl_state == 2'd1)
    |=> mem[$past(vpn)][14:13] == 2'd2);

  // R3
  wen_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_mapped && !mp_wr) |=> mem[$past(vpn)][15] == $past(xl_wen));

  // R4
  store_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_mapped && !xl_fault && !mp_wr && xl_write && xl_state != 2'd0)
    |=> mem[$past(vpn)][14:13] == 2'd3);

  // R5
  absent_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_mapped && xl_state == 2'd0 && !mp_wr) |=> mem[$past(vpn)] == $past(mem[vpn]));

  // R6
  fault_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_fault && !mp_wr) |=> mem[$past(vpn)] == $past(mem[vpn]));

  // R7
  cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_wr && mp_word) |=> mem[$past(mp_idx)] == $past(mp_wdata));
endmodule

// File: tb/sim_pgmap_xlate.sv
module sim_pgmap_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xl_valid = 0, xl_write = 0, xl_fault = 0;
  logic [23:0] xl_addr = '0;
  logic        xl_mapped, xl_wen;
  logic [23:0] xl_paddr;
  logic [1:0]  xl_state;
  logic        mp_sel = 0, mp_we = 0, mp_word = 0;
  logic [10:0] mp_addr = '0;
  logic [15:0] mp_wdata = '0;
  logic [15:0] mp_rdata;

  always #4 clk = ~clk;

  pgmap_xlate u0 (
    .clk(clk), .rst_n(rst_n), .xl_valid(xl_valid), .xl_write(xl_write),
    .xl_addr(xl_addr), .xl_fault(xl_fault), .xl_mapped(xl_mapped),
    .xl_paddr(xl_paddr), .xl_state(xl_state), .xl_wen(xl_wen),
    .mp_sel(mp_sel), .mp_we(mp_we), .mp_word(mp_word), .mp_addr(mp_addr),
    .mp_wdata(mp_wdata), .mp_rdata(mp_rdata));

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] mdl [1024];

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] gen(input int v);
    logic [15:0] e;
    e[15]    = v[0];
    e[14:13] = v[2:1];
    e[12:10] = 3'(v >> 3) ^ 3'b101;
    e[9:0]   = 10'(v * 37 + 5);
    return e;
  endfunction

  function automatic logic [15:0] after(input logic [15:0] e, input bit wr);
    if (e[14:13] != 2'd0) begin
      if (wr) e[14:13] = 2'd3;
      else if (e[14:13] == 2'd1) e[14:13] = 2'd2;
    end
    return e;
  endfunction

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cpu_wr(input int idx, input bit word, input bit lo, input logic [15:0] d);
    mp_sel = 1; mp_we = 1; mp_word = word; mp_addr = {10'(idx), lo}; mp_wdata = d;
    step();
    mp_sel = 0; mp_we = 0;
  endtask

  task automatic rd(input int idx, input bit word, input bit lo, output logic [15:0] d);
    mp_sel = 1; mp_we = 0; mp_word = word; mp_addr = {10'(idx), lo};
    #1 d = mp_rdata;
    mp_sel = 0;
  endtask

  task automatic chk_entry(input string tag, input int idx);
    logic [15:0] d;
    rd(idx, 1'b1, 1'b0, d);
    chk(tag, 24'(d), 24'(mdl[idx]));
  endtask

  task automatic xl_go(input logic [23:0] a, input bit wr, input bit flt, input string tag);
    int v;
    v = int'(a[21:12]);
    xl_valid = 1; xl_write = wr; xl_fault = flt; xl_addr = a;
    #1;
    if (a[23:22] == 2'b00) begin
      chk({tag, " R1 mapped"}, 24'(xl_mapped), 24'd1);
      chk({tag, " R1 paddr"}, xl_paddr, {2'b00, mdl[v][9:0], a[11:0]});
      chk({tag, " R9 state"}, 24'(xl_state), 24'(mdl[v][14:13]));
      chk({tag, " R9 wen"}, 24'(xl_wen), 24'(mdl[v][15]));
      if (!flt) mdl[v] = after(mdl[v], wr);
    end else begin
      chk({tag, " R2 mapped"}, 24'(xl_mapped), 24'd0);
      chk({tag, " R2 paddr"}, xl_paddr, a);
    end
    @(posedge clk); @(negedge clk);
    xl_valid = 0; xl_write = 0; xl_fault = 0;
    chk_entry({tag, " entry"}, v);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    xl_addr = 24'h400123;
    #1 chk("reset R2 passthrough", xl_paddr, 24'h400123);
    chk("reset R2 unmapped", 24'(xl_mapped), 24'd0);
    rst_n = 1;
    step();

    for (int v = 0; v < 1024; v++) begin
      cpu_wr(v, 1'b1, 1'b0, gen(v));
      mdl[v] = gen(v);
    end

    // R8 exhaustive readback: words and bytes
    for (int v = 0; v < 1024; v++) begin
      rd(v, 1'b1, 1'b1, d); chk("R8 word", 24'(d), 24'(mdl[v]));
      rd(v, 1'b0, 1'b0, d); chk("R8 high byte", 24'(d), {16'h0, mdl[v][15:8]});
      rd(v, 1'b0, 1'b1, d); chk("R8 low byte", 24'(d), {16'h0, mdl[v][7:0]});
    end

    // R3 R4 R5 read sweep, then write sweep, then re-read sweep
    for (int v = 0; v < 1024; v++) xl_go({2'b00, 10'(v), 12'(v * 13 + 7)}, 1'b0, 1'b0, "R3 R5 read");
    for (int v = 0; v < 1024; v++) xl_go({2'b00, 10'(v), 12'(v * 29 + 3)}, 1'b1, 1'b0, "R4 write");
    for (int v = 0; v < 1024; v += 3) xl_go({2'b00, 10'(v), 12'(v)}, 1'b0, 1'b0, "R4 reread");

    // R2 unmapped sweep
    for (int i = 0; i < 64; i++) xl_go(24'h400000 + 24'(i * 24'h3_1357), i[0], 1'b0, "R2 unmapped");
    xl_go(24'hFFFFFF, 1'b1, 1'b0, "R2 top");

    // R6 fault suppression
    cpu_wr(5, 1'b1, 1'b0, 16'h23C1); mdl[5] = 16'h23C1;
    xl_go({2'b00, 10'd5, 12'h010}, 1'b0, 1'b1, "R6 fault read");
    xl_go({2'b00, 10'd5, 12'h020}, 1'b1, 1'b1, "R6 fault write");
    xl_go({2'b00, 10'd5, 12'h030}, 1'b0, 1'b0, "R6 nofault read");

    // R5 no valid, no change
    cpu_wr(6, 1'b1, 1'b0, 16'hA055); mdl[6] = 16'hA055;
    xl_valid = 0; xl_write = 1; xl_addr = {2'b00, 10'd6, 12'h000};
    step();
    xl_write = 0;
    chk_entry("R5 invalid access", 6);

    // R7 same-entry word write wins
    cpu_wr(7, 1'b1, 1'b0, 16'h2001); mdl[7] = 16'h2001;
    xl_valid = 1; xl_write = 1; xl_addr = {2'b00, 10'd7, 12'h444};
    mp_sel = 1; mp_we = 1; mp_word = 1; mp_addr = {10'd7, 1'b0}; mp_wdata = 16'hABCD;
    step();
    xl_valid = 0; xl_write = 0; mp_sel = 0; mp_we = 0;
    mdl[7] = 16'hABCD;
    chk_entry("R7 same entry word", 7);

    // R7 same-entry byte write: update dropped, only byte changes
    cpu_wr(10, 1'b1, 1'b0, 16'h2111); mdl[10] = 16'h2111;
    xl_valid = 1; xl_write = 0; xl_addr = {2'b00, 10'd10, 12'h000};
    mp_sel = 1; mp_we = 1; mp_word = 0; mp_addr = {10'd10, 1'b1}; mp_wdata = 16'h00E7;
    step();
    xl_valid = 0; mp_sel = 0; mp_we = 0;
    mdl[10] = 16'h21E7;
    chk_entry("R7 same entry byte", 10);

    // R7 different entries: both take effect
    cpu_wr(9, 1'b1, 1'b0, 16'hA3FF); mdl[9] = 16'hA3FF;
    xl_valid = 1; xl_write = 1; xl_addr = {2'b00, 10'd9, 12'h800};
    mp_sel = 1; mp_we = 1; mp_word = 1; mp_addr = {10'd8, 1'b0}; mp_wdata = 16'h1234;
    step();
    xl_valid = 0; xl_write = 0; mp_sel = 0; mp_we = 0;
    mdl[8] = 16'h1234; mdl[9] = 16'hE3FF;
    chk_entry("R7 other entry cpu", 8);
    chk_entry("R7 other entry xl", 9);

    // R8 byte writes
    cpu_wr(20, 1'b1, 1'b0, 16'h0000);
    cpu_wr(20, 1'b0, 1'b0, 16'hFF5A);
    cpu_wr(20, 1'b0, 1'b1, 16'h77C3);
    mdl[20] = 16'h5AC3;
    chk_entry("R8 byte writes", 20);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule